// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors kept in a small internal memory that the host fills and inspects through a word write port and a word read port. Each descriptor takes four consecutive words: a command/status word, a word whose upper half carries the frame length, a 32-bit buffer address and a link to the following descriptor. The host points the engine at a descriptor, pulses a start command, and the engine then handles every descriptor whose ownership bit grants it to the engine.

For each such descriptor the engine presents a transmit request (buffer address and length) and waits for a completion pulse carrying three error flags. It writes the flags back into the command/status word, clears the ownership bit, and follows the link. When it meets a descriptor still held by the host, it goes idle and flags a queue-end cause. Descriptors that do not describe a complete single-buffer frame are returned with an error and never requested. Sticky cause bits, a mask and a summary output form the interrupt side. An abort command halts the engine at once.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset the engine is idle (`running` low), `txReqValid` and `abortBusy` are low, `curPtr` is 0 and all cause bits are 0.
- R2: A start pulse on an idle engine whose current descriptor has the ownership bit (command bit 31) set, with both frame-boundary flags (bit 17 first, bit 16 last), sets `running` on the next clock edge and `txReqValid` on the edge after that. The request carries buffer address word (offset 2), and length equals bits 31:16 of the length word (offset 1).
- R3: A `txDone` pulse ends the request. On the following edge the command word is rewritten with bit 31 cleared, bits 2:0 replaced by `txDoneStatus` (bit 0 retry limit, bit 1 underrun, bit 2 late collision), bit 15 set to the OR of those flags, and all other bits kept.
- R4: Each written-back descriptor moves `curPtr` (byte address, 16 bytes per descriptor) to the value in its link word (offset 3), so the last descriptor's link wraps the ring.
- R5: Meeting a descriptor with bit 31 clear stops the engine (`running` low) without a request, and sets cause bit 1 (queue end).
- R6: A write-back sets cause bit 0 (buffer done) only when the descriptor's interrupt-enable bit 23 is set, and sets cause bit 2 (transmit error) whenever bit 15 is written as 1.
- R7: An engine-owned descriptor lacking bit 17 or bit 16 gets no request. It is written back with bit 31 cleared and bit 15 set, and the engine advances.
- R8: After stopping, the engine stays idle until a new start pulse, even when the host grants it descriptors. A host write to `curPtr` is accepted only while idle.
- R9: An abort pulse drops any pending request and stops the engine on the next edge. `abortBusy` is high for that one cycle and then clears. The interrupted descriptor keeps bit 31 and `curPtr` is unchanged.
- R10: Cause bits stay set until the host writes a 1 to the matching `causeClr` bit (a new event wins over a clear). `intSummary` is the OR of the cause bits that `intMask` enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write to descriptor memory |
| hostWrAddr | input | WIDX_W | Word index of host write |
| hostWrData | input | 32 | Host write data |
| hostRdAddr | input | WIDX_W | Word index of host read |
| hostRdData | output | 32 | Word at hostRdAddr (combinational) |
| ptrWrEn | input | 1 | Host write of current-descriptor pointer |
| ptrWrData | input | PTR_W | New pointer (byte address) |
| curPtr | output | PTR_W | Current-descriptor pointer |
| startCmd | input | 1 | Start pulse |
| abortCmd | input | 1 | Abort pulse |
| abortBusy | output | 1 | Abort in progress |
| running | output | 1 | Queue running |
| txReqValid | output | 1 | Transmit request pending |
| txReqAddr | output | 32 | Buffer address of request |
| txReqLen | output | LEN_W | Frame length of request |
| txDone | input | 1 | Completion pulse |
| txDoneStatus | input | 3 | Completion error flags |
| causeClr | input | 3 | Write-one-to-clear cause bits |
| intMask | input | 3 | Cause enable mask |
| cause | output | 3 | Sticky causes: 0 done, 1 queue end, 2 error |
| intSummary | output | 1 | OR of enabled causes |

## Verification
A start sampled on edge N raises `running` after N and `txReqValid` after N+1. A completion sampled on edge K yields the rewritten command word, the new pointer and any causes after K+1. The last descriptor's queue-end stop shows one edge after it is fetched. An abort shows `abortBusy` with the engine stopped after the sampling edge, and `abortBusy` clears one edge later. The bench drives every input at the falling edge and reads outputs and memory there, stepping exactly the counted number of falling edges before each comparison. Where the number of intervening descriptors varies, it polls `txReqValid` or `running` with a bounded loop.

// File: rtl/tx_desc_ring_pkg.sv
package tx_desc_ring_pkg;
  localparam int WORD_W     = 32;
  localparam int OWN_BIT    = 31;
  localparam int INTEN_BIT  = 23;
  localparam int FIRST_BIT  = 17;
  localparam int LAST_BIT   = 16;
  localparam int ERRSUM_BIT = 15;
  localparam int LEN_LSB    = 16;
  localparam int STAT_W     = 3;
  localparam int NUM_CAUSE  = 3;
  localparam int CAUSE_DONE = 0;
  localparam int CAUSE_QEND = 1;
  localparam int CAUSE_ERR  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_REQ, ST_WB} ringState_t;

  typedef struct packed {
    logic latchReq;
    logic latchStat;
    logic badFrame;
    logic writeBack;
    logic setQueueEnd;
    logic ptrWrOk;
  } ringStrobe_t;
endpackage

// File: rtl/tx_desc_ring_ctl.sv
module tx_desc_ring_ctl
  import tx_desc_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCmd,
  input  logic        abortCmd,
  input  logic        txDone,
  input  logic        descOwned,
  input  logic        descWellFormed,
  output ringStrobe_t strobe,
  output logic        running,
  output logic        abortBusy,
  output logic        txReqValid
);
  ringState_t state, nextState;

  always_comb begin
    strobe = '0;
    nextState = state;
    strobe.ptrWrOk = (state == ST_IDLE);
    if (abortCmd) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (startCmd) nextState = ST_FETCH;
        ST_FETCH: begin
          if (!descOwned) begin
            strobe.setQueueEnd = 1'b1;
            nextState = ST_IDLE;
          end else if (!descWellFormed) begin
            strobe.badFrame = 1'b1;
            nextState = ST_WB;
          end else begin
            strobe.latchReq = 1'b1;
            nextState = ST_REQ;
          end
        end
        ST_REQ: if (txDone) begin
          strobe.latchStat = 1'b1;
          nextState = ST_WB;
        end
        ST_WB: begin
          strobe.writeBack = 1'b1;
          nextState = ST_FETCH;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      abortBusy <= 1'b0;
    end else begin
      state     <= nextState;
      abortBusy <= abortCmd;
    end
  end

  assign running    = (state != ST_IDLE);
  assign txReqValid = (state == ST_REQ);
endmodule

// File: rtl/tx_desc_ring_dp.sv
module tx_desc_ring_dp
  import tx_desc_ring_pkg::*;
#(
  parameter int DESC_COUNT = 8,
  parameter int LEN_W      = 16,
  localparam int DIDX_W    = $clog2(DESC_COUNT),
  localparam int WIDX_W    = DIDX_W + 2,
  localparam int PTR_W     = WIDX_W + 2,
  localparam int WORDS     = DESC_COUNT * 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [WIDX_W-1:0] hostWrAddr,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic [WIDX_W-1:0] hostRdAddr,
  output logic [WORD_W-1:0] hostRdData,
  input  logic              ptrWrEn,
  input  logic [PTR_W-1:0]  ptrWrData,
  output logic [PTR_W-1:0]  curPtr,
  input  ringStrobe_t       strobe,
  output logic              descOwned,
  output logic              descWellFormed,
  output logic [WORD_W-1:0] txReqAddr,
  output logic [LEN_W-1:0]  txReqLen,
  input  logic [STAT_W-1:0] txDoneStatus,
  input  logic [NUM_CAUSE-1:0] causeClr,
  input  logic [NUM_CAUSE-1:0] intMask,
  output logic [NUM_CAUSE-1:0] cause,
  output logic              intSummary
);
  logic [WORD_W-1:0] mem [WORDS];
  logic [DIDX_W-1:0] curIdx;
  logic [STAT_W-1:0] statReg;
  logic              badReg;
  logic [WORD_W-1:0] cmdWord, cntWord, bufWord, linkWord, wbWord;
  logic              wbErr;
  logic [NUM_CAUSE-1:0] causeSet;
  logic              unusedBits;

  assign cmdWord  = mem[{curIdx, 2'd0}];
  assign cntWord  = mem[{curIdx, 2'd1}];
  assign bufWord  = mem[{curIdx, 2'd2}];
  assign linkWord = mem[{curIdx, 2'd3}];
  assign hostRdData = mem[hostRdAddr];
  assign curPtr = {curIdx, 4'd0};

  assign descOwned      = cmdWord[OWN_BIT];
  assign descWellFormed = cmdWord[FIRST_BIT] & cmdWord[LAST_BIT];

  assign wbErr = (|statReg) | badReg;
  always_comb begin
    wbWord = cmdWord;
    wbWord[OWN_BIT] = 1'b0;
    wbWord[STAT_W-1:0] = statReg;
    wbWord[ERRSUM_BIT] = wbErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (hostWrEn) mem[hostWrAddr] <= hostWrData;
      if (strobe.writeBack) mem[{curIdx, 2'd0}] <= wbWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx    <= '0;
      statReg   <= '0;
      badReg    <= 1'b0;
      txReqAddr <= '0;
      txReqLen  <= '0;
    end else begin
      if (strobe.writeBack) curIdx <= linkWord[4 +: DIDX_W];
      else if (ptrWrEn && strobe.ptrWrOk) curIdx <= ptrWrData[PTR_W-1:4];
      if (strobe.latchReq) begin
        txReqAddr <= bufWord;
        txReqLen  <= cntWord[LEN_LSB +: LEN_W];
      end
      if (strobe.latchStat) begin
        statReg <= txDoneStatus;
        badReg  <= 1'b0;
      end else if (strobe.badFrame) begin
        statReg <= '0;
        badReg  <= 1'b1;
      end
    end
  end

  always_comb begin
    causeSet = '0;
    causeSet[CAUSE_DONE] = strobe.writeBack & cmdWord[INTEN_BIT];
    causeSet[CAUSE_QEND] = strobe.setQueueEnd;
    causeSet[CAUSE_ERR]  = strobe.writeBack & wbErr;
  end

  for (genvar c = 0; c < NUM_CAUSE; c++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rstN) cause[c] <= 1'b0;
      else cause[c] <= causeSet[c] | (cause[c] & ~causeClr[c]);
    end
  end

  assign intSummary = |(cause & intMask);
  assign unusedBits = ^{cntWord[LEN_LSB-1:0], linkWord, ptrWrData[3:0]};
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import tx_desc_ring_pkg::*;
#(
  parameter int DESC_COUNT = 8,
  parameter int LEN_W      = 16,
  localparam int WIDX_W    = $clog2(DESC_COUNT) + 2,
  localparam int PTR_W     = WIDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [WIDX_W-1:0] hostWrAddr,
  input  logic [31:0]       hostWrData,
  input  logic [WIDX_W-1:0] hostRdAddr,
  output logic [31:0]       hostRdData,
  input  logic              ptrWrEn,
  input  logic [PTR_W-1:0]  ptrWrData,
  output logic [PTR_W-1:0]  curPtr,
  input  logic              startCmd,
  input  logic              abortCmd,
  output logic              abortBusy,
  output logic              running,
  output logic              txReqValid,
  output logic [31:0]       txReqAddr,
  output logic [LEN_W-1:0]  txReqLen,
  input  logic              txDone,
  input  logic [2:0]        txDoneStatus,
  input  logic [2:0]        causeClr,
  input  logic [2:0]        intMask,
  output logic [2:0]        cause,
  output logic              intSummary
);
  ringStrobe_t strobe;
  logic descOwned, descWellFormed;

  tx_desc_ring_ctl u_ctl (
    .clk, .rstN, .startCmd, .abortCmd, .txDone,
    .descOwned, .descWellFormed, .strobe,
    .running, .abortBusy, .txReqValid
  );

  tx_desc_ring_dp #(.DESC_COUNT(DESC_COUNT), .LEN_W(LEN_W)) u_dp (
    .clk, .rstN, .hostWrEn, .hostWrAddr, .hostWrData,
    .hostRdAddr, .hostRdData, .ptrWrEn, .ptrWrData, .curPtr,
    .strobe, .descOwned, .descWellFormed, .txReqAddr, .txReqLen,
    .txDoneStatus, .causeClr, .intMask, .cause, .intSummary
  );
endmodule

// File: rtl/tx_desc_ring_chk.sv
module tx_desc_ring_chk #(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             running,
  input logic             txReqValid,
  input logic             txDone,
  input logic             abortBusy,
  input logic [PTR_W-1:0] curPtr,
  input logic [2:0]       cause,
  input logic [2:0]       causeClr
);
  a_r2_req_only_running: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid |-> running);

  a_r3_done_ends_req: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid && txDone |=> !txReqValid);

  a_r4_ptr_hold_in_req: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid && $past(txReqValid) |-> $stable(curPtr));

  a_r5_stop_flags_qend: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) && !abortBusy |-> cause[1]);

  a_r9_abort_stops: assert property (@(posedge clk) disable iff (!rstN)
    abortBusy |-> !running && !txReqValid);

  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (($past(cause) & ~$past(causeClr)) & ~cause) == 3'b000);
endmodule

bind tx_desc_ring tx_desc_ring_chk #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/test_tx_desc_ring.sv
`timescale 1ns/1ps
module test_tx_desc_ring;
  localparam int WIDX_W = 5;
  localparam int PTR_W  = 7;
  localparam logic [31:0] OWN = 32'h8000_0000, INTEN = 32'h0080_0000,
                          FIRST = 32'h0002_0000, LAST = 32'h0001_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [WIDX_W-1:0] hostWrAddr = '0, hostRdAddr = '0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic ptrWrEn = 1'b0;
  logic [PTR_W-1:0] ptrWrData = '0, curPtr;
  logic startCmd = 1'b0, abortCmd = 1'b0, abortBusy, running, txReqValid;
  logic [31:0] txReqAddr;
  logic [15:0] txReqLen;
  logic txDone = 1'b0;
  logic [2:0] txDoneStatus = '0, causeClr = '0, intMask = '0, cause;
  logic intSummary;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tx_desc_ring i_tx_desc_ring (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic wrWord(int a, logic [31:0] d);
    @(negedge clk); hostWrEn = 1'b1; hostWrAddr = a[WIDX_W-1:0]; hostWrData = d;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic putDesc(int idx, logic [31:0] cmd, int len, logic [31:0] buff, int nextIdx);
    wrWord(idx*4, cmd);
    wrWord(idx*4+1, 32'(len) << 16);
    wrWord(idx*4+2, buff);
    wrWord(idx*4+3, 32'(nextIdx*16));
  endtask

  task automatic rdWord(int a, output logic [31:0] d);
    hostRdAddr = a[WIDX_W-1:0]; #1; d = hostRdData;
  endtask

  task automatic pulseStart();
    @(negedge clk); startCmd = 1'b1;
    @(negedge clk); startCmd = 1'b0;
  endtask

  task automatic clearCauses();
    @(negedge clk); causeClr = 3'b111;
    @(negedge clk); causeClr = 3'b000;
  endtask

  task automatic writePtr(int p);
    @(negedge clk); ptrWrEn = 1'b1; ptrWrData = p[PTR_W-1:0];
    @(negedge clk); ptrWrEn = 1'b0;
  endtask

  task automatic serve(string req, int idx, logic [31:0] expAddr, int expLen,
                       logic [2:0] st, logic [31:0] expCmd);
    logic [31:0] w;
    for (int i = 0; i < 50 && !txReqValid; i++) @(negedge clk);
    chk({req, " request valid"}, 32'(txReqValid), 1);
    chk({req, " request address"}, txReqAddr, expAddr);
    chk({req, " request length"}, 32'(txReqLen), 32'(expLen));
    txDone = 1'b1; txDoneStatus = st;
    @(negedge clk); txDone = 1'b0; txDoneStatus = '0;
    @(negedge clk);
    rdWord(idx*4, w);
    chk("R3 written-back command word", w, expCmd);
  endtask

  task automatic waitStop(output bit sawReq);
    sawReq = 0;
    for (int i = 0; i < 100 && running; i++) begin
      if (txReqValid) sawReq = 1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 running after reset", 32'(running), 0);
    chk("R1 request after reset", 32'(txReqValid), 0);
    chk("R1 abortBusy after reset", 32'(abortBusy), 0);
    chk("R1 pointer after reset", 32'(curPtr), 0);
    chk("R1 causes after reset", 32'(cause), 0);
  endtask

  task automatic t_ring();
    bit saw;
    putDesc(0, OWN | INTEN | FIRST | LAST, 64, 32'h1000_0000, 1);
    putDesc(1, OWN | FIRST | LAST, 1500, 32'h2000_0040, 2);
    putDesc(2, FIRST | LAST, 60, 32'h3000_0000, 0);
    pulseStart();
    chk("R2 running one edge after start", 32'(running), 1);
    chk("R2 no request yet", 32'(txReqValid), 0);
    @(negedge clk);
    chk("R2 request two edges after start", 32'(txReqValid), 1);
    serve("R2 d0", 0, 32'h1000_0000, 64, 3'b000, 32'h0083_0000);
    chk("R4 pointer after first descriptor", 32'(curPtr), 16);
    serve("R2 d1", 1, 32'h2000_0040, 1500, 3'b010, 32'h0003_8002);
    waitStop(saw);
    chk("R5 stopped at host-owned descriptor", 32'(running), 0);
    chk("R4 pointer at stop", 32'(curPtr), 32);
    chk("R6 R5 causes after ring", 32'(cause), 3'b111);
  endtask

  task automatic t_summary();
    @(negedge clk); intMask = 3'b100; #1;
    chk("R10 summary error cause enabled", 32'(intSummary), 1);
    intMask = 3'b000; #1;
    chk("R10 summary all masked", 32'(intSummary), 0);
    @(negedge clk); causeClr = 3'b101;
    @(negedge clk); causeClr = 3'b000;
    chk("R10 selective clear", 32'(cause), 3'b010);
    @(negedge clk);
    chk("R10 cause sticky", 32'(cause), 3'b010);
    intMask = 3'b101; #1;
    chk("R10 summary cleared causes", 32'(intSummary), 0);
    intMask = 3'b010; #1;
    chk("R10 summary queue end", 32'(intSummary), 1);
    intMask = 3'b000;
    clearCauses();
  endtask

  task automatic t_wrap();
    bit saw;
    wrWord(8, OWN | FIRST | LAST);
    pulseStart();
    @(negedge clk);
    ptrWrEn = 1'b1; ptrWrData = 7'd16;
    @(negedge clk); ptrWrEn = 1'b0;
    serve("R8 d2", 2, 32'h3000_0000, 60, 3'b000, 32'h0003_0000);
    waitStop(saw);
    chk("R4 R8 pointer wrapped, busy write ignored", 32'(curPtr), 0);
    chk("R6 no done cause without enable", 32'(cause), 3'b010);
    clearCauses();
    wrWord(0, OWN | FIRST | LAST);
    repeat (6) @(negedge clk);
    chk("R8 no restart without start", 32'(running), 0);
    chk("R8 no request without start", 32'(txReqValid), 0);
    pulseStart();
    serve("R3 d0 errors", 0, 32'h1000_0000, 64, 3'b101, 32'h0003_8005);
    waitStop(saw);
    chk("R4 pointer after d0", 32'(curPtr), 16);
    chk("R6 error cause", 32'(cause), 3'b110);
    clearCauses();
  endtask

  task automatic t_bad();
    bit saw;
    logic [31:0] w;
    wrWord(4, OWN | LAST);
    pulseStart();
    waitStop(saw);
    chk("R7 no request for malformed", 32'(saw), 0);
    rdWord(4, w);
    chk("R7 malformed written back", w, 32'h0001_8000);
    chk("R7 advanced past malformed", 32'(curPtr), 32);
    chk("R7 causes", 32'(cause), 3'b110);
    clearCauses();
  endtask

  task automatic t_abort();
    logic [31:0] w;
    writePtr(16);
    chk("R8 pointer write while idle", 32'(curPtr), 16);
    wrWord(4, OWN | FIRST | LAST);
    pulseStart();
    for (int i = 0; i < 20 && !txReqValid; i++) @(negedge clk);
    chk("R9 request before abort", 32'(txReqValid), 1);
    abortCmd = 1'b1;
    @(negedge clk); abortCmd = 1'b0;
    chk("R9 abortBusy set", 32'(abortBusy), 1);
    chk("R9 stopped at once", 32'(running), 0);
    chk("R9 request dropped", 32'(txReqValid), 0);
    @(negedge clk);
    chk("R9 abortBusy cleared", 32'(abortBusy), 0);
    rdWord(4, w);
    chk("R9 descriptor still owned", w, OWN | FIRST | LAST);
    chk("R9 pointer unchanged", 32'(curPtr), 16);
    chk("R9 no cause on abort", 32'(cause), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ring();
    t_summary();
    t_wrap();
    t_bad();
    t_abort();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule